// File: doc/BRIEF.md
# SECDED Read-Path Checker with Per-Sector Bypass

This block sits between a flash-like memory bank and the bus that reads it. Each read brings a 64-bit data word, the 8-bit check byte stored with it, the byte address and the 4-bit index of the sector the word lives in. The block decodes the check byte and returns the word. A single-bit error is corrected in the returned data only; nothing is ever written back to the array. A double-bit error is flagged as uncorrectable and the read is answered with a bus abort.

A small register port lets software configure the block at run time:
- turn checking on or off as a whole;
- name up to four sectors whose reads bypass the decoder, so they pass through raw and raise no flags;
- keep an uncorrectable error off the interrupt and the external error line.

Correction and double-error detection are always enabled or disabled together. Sticky flags and the address of the last failing read are kept for software.

Control is a two-state machine, `rd_state_e`:
- `ST_IDLE`: the block accepts a request. The transition *accept* (`req_valid` while idle) registers the decoded result and moves to `ST_HOLD`.
- `ST_HOLD`: the block presents the response. The transition *release* (`rsp_ready` high) returns to `ST_IDLE`.

Top module: `secded_rd_check`

## Requirements
- R1: Code definition. Data bit j sits at the (j+1)-th integer ≥3 that is not a power of two, counting up. Check bit i (i = 0..6) is the XOR of the data bits whose position has bit i set. Check bit 7 is the XOR of all 64 data bits and check bits 0..6. A read of an unaltered word returns the data unchanged with `rsp_ce`, `rsp_ue` and `rsp_abort` all 0.
- R2: A read whose word differs from a valid codeword in exactly one data bit returns the corrected data, with `rsp_ce`=1, `rsp_ue`=0 and `rsp_abort`=0.
- R3: A read with exactly one flipped bit in the check byte (any of bits 0..7) returns the data unchanged with `rsp_ce`=1 and `rsp_ue`=0.
- R4: A read with exactly two flipped bits anywhere in the 72 stored bits returns the received data unmodified, with `rsp_ue`=1, `rsp_abort`=1 and `rsp_ce`=0.
- R5: Register 1 holds four bypass entries. Entry k occupies `reg_wdata[5k+4:5k]`, with bit 5k+4 as the valid bit and bits 5k+3:5k as the sector index. A read whose `req_sector` equals the index of a valid entry returns raw data with all flags 0. An entry whose valid bit is 0 matches no sector.
- R6: Register 0 bit 0 is the global enable and resets to 1. While it is 0, every read returns raw data with all flags 0. Writing 1 again restores checking.
- R7: Register 0 bit 1 is the uncorrectable mask and resets to 0. While it is set, an uncorrectable read still aborts, but `err_out` does not pulse and `irq` stays low.
- R8: Register 2 holds sticky flags: bit 0 is correctable and bit 1 is uncorrectable. Each is set by a read that reports it. Each is cleared by writing 1 to its bit, and writing 0 leaves it alone.
- R9: Register 3 returns the `req_addr` of the most recent read that reported a correctable or uncorrectable error. Clean reads leave it unchanged.
- R10: `req_ready` is 1 only in `ST_IDLE`. After an accept, the response appears in the next cycle and is held unchanged while `rsp_ready` is 0.
- R11: `err_out` is a one-cycle pulse in the first response cycle of an unmasked uncorrectable read. `irq` equals the sticky uncorrectable flag with the mask cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Byte address of the read |
| req_sector | input | 4 | Sector index of the read |
| req_data | input | 64 | Stored data word |
| req_chk | input | 8 | Stored check byte |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 64 | Returned (possibly corrected) data |
| rsp_ce | output | 1 | Correctable error flag |
| rsp_ue | output | 1 | Uncorrectable error flag |
| rsp_abort | output | 1 | Bus abort for this read |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 20 | Register write data |
| reg_rdata | output | 32 | Register read data |
| irq | output | 1 | Interrupt level |
| err_out | output | 1 | External error pulse |

## Verification
The decoder is exercised with four kinds of input:
- clean random codewords;
- each of the 64 data bits flipped on its own;
- each of the 8 check bits flipped on its own;
- every pair of the 72 stored bits flipped.

Together these separate correction, check-byte-only errors and double detection, and they catch any position-map or parity mistake. A sweep over all 16 sectors is run with single and double errors under a mix of valid and invalid bypass entries; it shows that only valid matching entries bypass the decoder. Further sequences toggle the enable and the mask, clear the sticky flags bit by bit, and stall the response to show it holds.

// File: rtl/secded_pkg.sv
package secded_pkg;

    function automatic int chk_bits(input int dw);
        int p;
        p = 0;
        while ((1 << p) < dw + p + 1) p++;
        return p;
    endfunction

    function automatic int data_pos(input int j);
        int res;
        int cnt;
        res = 0;
        cnt = 0;
        for (int k = 3; k < 4096; k++) begin
            if (res == 0 && (k & (k - 1)) != 0) begin
                if (cnt == j) res = k;
                cnt++;
            end
        end
        return res;
    endfunction

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } rd_state_e;

    localparam logic [1:0] REG_CTRL   = 2'd0;
    localparam logic [1:0] REG_BYPASS = 2'd1;
    localparam logic [1:0] REG_STAT   = 2'd2;
    localparam logic [1:0] REG_FADDR  = 2'd3;

endpackage

// File: rtl/secded_decode.sv
module secded_decode #(
    parameter int DATA_W = 64,
    localparam int P     = secded_pkg::chk_bits(DATA_W),
    localparam int CHK_W = P + 1
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [CHK_W-1:0]  chk_i,
    output logic [DATA_W-1:0] data_o,
    output logic              ce_o,
    output logic              ue_o
);
    logic [P-1:0]      contrib [DATA_W];
    logic [DATA_W-1:0] hit;
    logic [P-1:0]      syn;
    logic              par;
    logic              single_ok;

    for (genvar j = 0; j < DATA_W; j++) begin : g_col
        localparam int POS = secded_pkg::data_pos(j);
        localparam logic [P-1:0] POSV = POS[P-1:0];
        assign contrib[j] = data_i[j] ? POSV : '0;
        assign hit[j]     = (syn == POSV);
    end

    always_comb begin
        logic [P-1:0] acc;
        acc = '0;
        for (int j = 0; j < DATA_W; j++) acc = acc ^ contrib[j];
        syn = acc ^ chk_i[P-1:0];
    end

    always_comb begin
        par       = (^data_i) ^ (^chk_i);
        single_ok = par && ((syn == '0) || $onehot(syn) || (|hit));
        ce_o      = single_ok;
        ue_o      = ((syn != '0) && !par) || (par && !single_ok);
        data_o    = data_i ^ (single_ok ? hit : '0);
    end

endmodule

// File: rtl/sector_gate.sv
module sector_gate #(
    parameter int SECT_W = 4,
    parameter int N_DIS  = 4,
    localparam int ENT_W = SECT_W + 1,
    localparam int CFG_W = N_DIS * ENT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic [SECT_W-1:0] sector_i,
    output logic              match_o,
    output logic [CFG_W-1:0]  cfg_o
);
    logic [N_DIS-1:0] hit;

    for (genvar k = 0; k < N_DIS; k++) begin : g_ent
        logic [ENT_W-1:0] ent_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      ent_q <= '0;
            else if (cfg_we) ent_q <= cfg_wdata[k*ENT_W +: ENT_W];
        end
        assign hit[k] = ent_q[ENT_W-1] && (ent_q[SECT_W-1:0] == sector_i);
        assign cfg_o[k*ENT_W +: ENT_W] = ent_q;
    end

    assign match_o = |hit;

endmodule

// File: rtl/secded_rd_check.sv
module secded_rd_check #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 32,
    parameter int SECT_W = 4,
    parameter int N_DIS  = 4,
    parameter int REG_W  = 32,
    localparam int CHK_W = secded_pkg::chk_bits(DATA_W) + 1,
    localparam int CFG_W = N_DIS * (SECT_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SECT_W-1:0] req_sector,
    input  logic [DATA_W-1:0] req_data,
    input  logic [CHK_W-1:0]  req_chk,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_ce,
    output logic              rsp_ue,
    output logic              rsp_abort,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [CFG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq,
    output logic              err_out
);
    import secded_pkg::*;

    rd_state_e state_q, state_d;

    logic              en_q, mask_q;
    logic              ce_st_q, ue_st_q;
    logic [ADDR_W-1:0] faddr_q;
    logic              err_q;
    logic [DATA_W-1:0] data_q;
    logic              ce_q, ue_q;

    logic [DATA_W-1:0] dec_data;
    logic              dec_ce, dec_ue;
    logic              sect_off;
    logic [CFG_W-1:0]  cfg_view;
    logic              accept, bypass, eff_ce, eff_ue;
    logic              wr_ctrl, wr_stat;

    secded_decode #(.DATA_W(DATA_W)) u_dec (
        .data_i (req_data),
        .chk_i  (req_chk),
        .data_o (dec_data),
        .ce_o   (dec_ce),
        .ue_o   (dec_ue)
    );

    sector_gate #(.SECT_W(SECT_W), .N_DIS(N_DIS)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (reg_we && reg_addr == REG_BYPASS),
        .cfg_wdata (reg_wdata),
        .sector_i  (req_sector),
        .match_o   (sect_off),
        .cfg_o     (cfg_view)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and handshake outputs
    always_comb begin
        state_d   = state_q;
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                rsp_valid = 1'b1;
                if (rsp_ready) state_d = ST_IDLE;
            end
        endcase
    end

    assign accept  = req_valid && req_ready;
    assign bypass  = !en_q || sect_off;
    assign eff_ce  = !bypass && dec_ce;
    assign eff_ue  = !bypass && dec_ue;
    assign wr_ctrl = reg_we && reg_addr == REG_CTRL;
    assign wr_stat = reg_we && reg_addr == REG_STAT;

    // response capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            ce_q   <= 1'b0;
            ue_q   <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            err_q <= accept && eff_ue && !mask_q;
            if (accept) begin
                data_q <= bypass ? req_data : dec_data;
                ce_q   <= eff_ce;
                ue_q   <= eff_ue;
            end
        end
    end

    // control and status registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b1;
            mask_q  <= 1'b0;
            ce_st_q <= 1'b0;
            ue_st_q <= 1'b0;
            faddr_q <= '0;
        end else begin
            if (wr_ctrl) begin
                en_q   <= reg_wdata[0];
                mask_q <= reg_wdata[1];
            end
            ce_st_q <= (ce_st_q && !(wr_stat && reg_wdata[0])) || (accept && eff_ce);
            ue_st_q <= (ue_st_q && !(wr_stat && reg_wdata[1])) || (accept && eff_ue);
            if (accept && (eff_ce || eff_ue)) faddr_q <= req_addr;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            REG_CTRL:   reg_rdata[1:0]       = {mask_q, en_q};
            REG_BYPASS: reg_rdata[CFG_W-1:0] = cfg_view;
            REG_STAT:   reg_rdata[1:0]       = {ue_st_q, ce_st_q};
            REG_FADDR:  reg_rdata[ADDR_W-1:0] = faddr_q;
        endcase
    end

    assign rsp_data  = data_q;
    assign rsp_ce    = rsp_valid && ce_q;
    assign rsp_ue    = rsp_valid && ue_q;
    assign rsp_abort = rsp_valid && ue_q;
    assign irq       = ue_st_q && !mask_q;
    assign err_out   = err_q;

endmodule

// File: rtl/secded_rd_check_sva.sv
module secded_rd_check_sva #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [DATA_W-1:0] rsp_data,
    input logic              rsp_ce,
    input logic              rsp_ue,
    input logic              rsp_abort,
    input logic              err_out,
    input logic              mask
);
    AST_CE_UE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(rsp_ce && rsp_ue)); // R2

    AST_UE_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ue) |-> rsp_abort); // R4

    AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready); // R10

    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R10

    AST_ERR_IS_UE: assert property (@(posedge clk) disable iff (!rst_n)
        err_out |-> (rsp_valid && rsp_ue)); // R11

    AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        err_out |-> !$past(mask)); // R7

endmodule

bind secded_rd_check secded_rd_check_sva #(.DATA_W(DATA_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data),
    .rsp_ce    (rsp_ce),
    .rsp_ue    (rsp_ue),
    .rsp_abort (rsp_abort),
    .err_out   (err_out),
    .mask      (mask_q)
);

// File: tb/test_secded_rd_check.sv
module test_secded_rd_check;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_sector = '0;
    logic [63:0] req_data = '0;
    logic [7:0]  req_chk = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [63:0] rsp_data;
    logic        rsp_ce, rsp_ue, rsp_abort;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [19:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, err_out;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;

    logic [63:0] o_data;
    logic        o_ce, o_ue, o_ab, o_err;

    secded_rd_check i_secded_rd_check (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_sector(req_sector), .req_data(req_data), .req_chk(req_chk),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
        .rsp_ce(rsp_ce), .rsp_ue(rsp_ue), .rsp_abort(rsp_abort),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .err_out(err_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    function automatic logic [7:0] encode(input logic [63:0] d);
        logic [6:0] c;
        int k;
        c = '0;
        k = 3;
        for (int j = 0; j < 64; j++) begin
            while ((k & (k - 1)) == 0) k++;
            if (d[j]) c = c ^ k[6:0];
            k++;
        end
        return {(^d) ^ (^c), c};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [31:0] a, input logic [3:0] s, input logic [63:0] d, input logic [7:0] c);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_sector = s; req_data = d; req_chk = c;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        o_data = rsp_data; o_ce = rsp_ce; o_ue = rsp_ue; o_ab = rsp_abort; o_err = err_out;
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [19:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rdreg(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic expect_rsp(input string req, input logic [63:0] d, input bit ce, input bit ue);
        check(o_data == d, req, o_data, d);
        check(o_ce == ce && o_ue == ue && o_ab == ue, req, {61'd0, o_ce, o_ue, o_ab}, {61'd0, ce, ue, ue});
    endtask

    initial begin
        logic [63:0] d, dd;
        logic [7:0]  c, cc;
        logic [71:0] cw;
        logic [31:0] v;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        check(req_ready && !rsp_valid && !irq && !err_out, "R10", {60'd0, req_ready, rsp_valid, irq, err_out}, 64'h8);
        rdreg(2'd0, v); check(v == 32'h1, "R6", {32'd0, v}, 64'h1);
        rdreg(2'd2, v); check(v == 32'h0, "R8", {32'd0, v}, 64'h0);

        // R1 clean words
        for (int t = 0; t < 32; t++) begin
            d = {$urandom, $urandom};
            if (t == 0) d = '0;
            if (t == 1) d = '1;
            rd(32'h100 + t, 4'd0, d, encode(d));
            expect_rsp("R1", d, 1'b0, 1'b0);
        end
        rdreg(2'd2, v); check(v == 32'h0, "R9", {32'd0, v}, 64'h0);

        // R2 every single data bit
        for (int b = 0; b < 64; b++) begin
            d = {$urandom, $urandom};
            c = encode(d);
            dd = d ^ (64'd1 << b);
            rd(32'h200 + b, 4'd1, dd, c);
            expect_rsp("R2", d, 1'b1, 1'b0);
        end
        // R3 every check bit
        for (int b = 0; b < 8; b++) begin
            d = {$urandom, $urandom};
            c = encode(d) ^ (8'd1 << b);
            rd(32'h300 + b, 4'd2, d, c);
            expect_rsp("R3", d, 1'b1, 1'b0);
        end
        // R4 every pair of stored bits
        d = 64'hA5C3_0F96_1234_FEDC;
        c = encode(d);
        for (int i = 0; i < 72; i++) begin
            for (int j = i + 1; j < 72; j++) begin
                cw = {c, d} ^ (72'd1 << i) ^ (72'd1 << j);
                rd(32'h400, 4'd3, cw[63:0], cw[71:64]);
                expect_rsp("R4", cw[63:0], 1'b0, 1'b1);
            end
        end

        // R5 sector bypass: valid 3, 7, 12; invalid entry holds 9
        wr(2'd1, {5'h1C, 5'h09, 5'h17, 5'h13});
        rdreg(2'd1, v); check(v == {12'd0, 5'h1C, 5'h09, 5'h17, 5'h13}, "R5", {32'd0, v}, {44'd0, 5'h1C, 5'h09, 5'h17, 5'h13});
        for (int s = 0; s < 16; s++) begin
            bit off;
            off = (s == 3) || (s == 7) || (s == 12);
            d = {$urandom, $urandom};
            c = encode(d);
            dd = d ^ 64'h0000_0100_0000_0000;
            rd(32'h500 + s, s[3:0], dd, c);
            expect_rsp("R5", off ? dd : d, !off, 1'b0);
            dd = d ^ 64'h0000_0000_0000_0011;
            rd(32'h600 + s, s[3:0], dd, c);
            expect_rsp("R5", dd, 1'b0, !off);
        end
        wr(2'd1, 20'd0);

        // R6 global enable off and on
        d = 64'h0123_4567_89AB_CDEF;
        c = encode(d);
        wr(2'd0, 20'h0);
        rd(32'h700, 4'd5, d ^ 64'h8, c);
        expect_rsp("R6", d ^ 64'h8, 1'b0, 1'b0);
        rd(32'h704, 4'd5, d ^ 64'h18, c);
        expect_rsp("R6", d ^ 64'h18, 1'b0, 1'b0);
        wr(2'd0, 20'h1);
        rd(32'h708, 4'd5, d ^ 64'h8, c);
        expect_rsp("R6", d, 1'b1, 1'b0);

        // R8 / R11 clear status, then unmasked UE
        wr(2'd2, 20'h3);
        rdreg(2'd2, v); check(v == 32'h0, "R8", {32'd0, v}, 64'h0);
        check(!irq, "R11", {63'd0, irq}, 64'h0);
        rd(32'hABCD_0120, 4'd6, d ^ 64'h3, c);
        check(o_err == 1'b1, "R11", {63'd0, o_err}, 64'h1);
        @(negedge clk);
        check(!err_out && irq, "R11", {62'd0, err_out, irq}, 64'h1);
        rdreg(2'd3, v); check(v == 32'hABCD_0120, "R9", {32'd0, v}, 64'hABCD_0120);
        rd(32'h1111_0000, 4'd6, d, c);
        rdreg(2'd3, v); check(v == 32'hABCD_0120, "R9", {32'd0, v}, 64'hABCD_0120);
        rd(32'h2222_0008, 4'd6, d ^ 64'h4, c);
        rdreg(2'd3, v); check(v == 32'h2222_0008, "R9", {32'd0, v}, 64'h2222_0008);
        rdreg(2'd2, v); check(v == 32'h3, "R8", {32'd0, v}, 64'h3);
        wr(2'd2, 20'h0);
        rdreg(2'd2, v); check(v == 32'h3, "R8", {32'd0, v}, 64'h3);
        wr(2'd2, 20'h2);
        rdreg(2'd2, v); check(v == 32'h1, "R8", {32'd0, v}, 64'h1);
        wr(2'd2, 20'h1);
        rdreg(2'd2, v); check(v == 32'h0, "R8", {32'd0, v}, 64'h0);

        // R7 mask
        wr(2'd0, 20'h3);
        rd(32'h800, 4'd7, d ^ 64'hC0, c);
        check(o_ab && o_ue && !o_err, "R7", {61'd0, o_ab, o_ue, o_err}, 64'h6);
        check(!irq, "R7", {63'd0, irq}, 64'h0);
        wr(2'd0, 20'h1);
        @(negedge clk);
        check(irq, "R11", {63'd0, irq}, 64'h1);
        wr(2'd2, 20'h3);

        // R10 stalled response
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h900; req_sector = 4'd8; req_data = d ^ 64'h1; req_chk = c;
        @(negedge clk);
        req_data = 64'hFFFF_0000_FFFF_0000; req_chk = 8'h00;
        for (int t = 0; t < 4; t++) begin
            check(rsp_valid && !req_ready, "R10", {62'd0, rsp_valid, req_ready}, 64'h2);
            check(rsp_data == d && rsp_ce, "R10", rsp_data, d);
            @(negedge clk);
        end
        req_valid = 1'b0;
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        check(req_ready && !rsp_valid, "R10", {62'd0, req_ready, rsp_valid}, 64'h2);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule